// File: doc/BRIEF.md
# Memory Protection Range Guard

This block is one channel group of a memory protection unit. It keeps four address points that bound two inclusive address windows, a protection enable, a comparator type selector, and a small set of permission bits per window. When the selector is 0 the windows guard instruction fetches and each window carries an execute permission. When the selector is 1 the windows guard operand accesses and each window carries separate read and write permissions.

The processor side presents an address, an access kind and a valid strobe each cycle. If the access lands inside at least one window and no window that contains it grants the needed permission, the block raises a sticky violation flag one cycle later and captures the address. Software programs the points and control word through a simple write port and clears the flag with a write-one-to-clear command. Windows that both contain an address are combined permissively, and addresses outside both windows are left alone.

Register indices on the write port: 0 to 3 are the points (0 and 1 bound window 0, 2 and 3 bound window 1), 4 is the control word, 5 is the clear command (bit 0). Control word layout: bit 0 enable, bit 1 comparator type, then for window w bit 2+3w execute, bit 3+3w read, bit 4+3w write. Access kind encoding: 0 fetch, 1 read, 2 write, 3 no access.

Top module: `mpu_range_guard`

## Requirements
- R1: A synchronous reset clears all points, all permission bits, the enable bit and the comparator type, and drives the violation flag to 0 and the captured address to 0.
- R2: While the enable bit (control bit 0) is 0, no access ever sets the violation flag, whatever the permission bits hold.
- R3: An address is inside a window when lower point <= address <= upper point, unsigned and inclusive at both ends; lower-1 and upper+1 are outside.
- R4: With comparator type 0, a fetch (kind 0) inside a window is a violation unless a window containing it has its execute bit set.
- R5: With comparator type 1, a read (kind 1) needs the read bit and a write (kind 2) needs the write bit of a window containing the address; otherwise it is a violation.
- R6: An access whose kind does not match the comparator type (reads and writes under type 0, fetches under type 1) and kind 3 never set the flag.
- R7: When an address lies in both windows, the access is allowed if either window grants the needed permission.
- R8: An address outside both windows never sets the flag.
- R9: A violation sets the flag and captures the address on the clock edge that samples the valid strobe, so both are visible one cycle later; while the flag stays set it holds the first captured address.
- R10: Writing 1 to bit 0 of index 5 clears the flag on the next edge; a violation in the same cycle as the clear wins and captures its new address.
- R11: A window whose lower point is greater than its upper point contains no address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Register index for the write |
| cfg_wdata | input | 32 | Write data |
| acc_valid | input | 1 | Access presented this cycle |
| acc_addr | input | 32 | Fetch or operand address |
| acc_kind | input | 2 | 0 fetch, 1 read, 2 write, 3 none |
| viol_flag | output | 1 | Sticky violation flag |
| viol_addr | output | 32 | Address of the first captured violation |

## Verification
Directed accesses sit exactly on each window's lower and upper point and one step outside them, which separates inclusive from exclusive and signed from unsigned comparison. Each access kind is sent under both comparator types with permission bits chosen so read, write and execute each grant a different outcome, which tells a crossed permission bit or an unfiltered kind apart from correct decoding. Overlapping windows, an inverted window and clears coinciding with new violations expose an AND-combined grant, a missing empty-window case and a wrong clear priority. Random windows placed close together with nearby addresses and random control words then mix all of these against a bench model.

// File: rtl/mpu_grp_pkg.sv
package mpu_grp_pkg;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2,
        ACC_NONE  = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic exec;
        logic rd;
        logic wr;
    } perm_t;

    localparam int unsigned CTRL_EN_BIT   = 0;
    localparam int unsigned CTRL_TYPE_BIT = 1;
    localparam int unsigned CTRL_PERM_LSB = 2;
    localparam int unsigned PERM_BITS     = 3;

endpackage

// File: rtl/mpu_cfg_regs.sv
module mpu_cfg_regs
    import mpu_grp_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned NUM_RANGES = 2,
    parameter int unsigned IDX_W      = 3
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  we_i,
    input  logic [IDX_W-1:0]                      idx_i,
    input  logic [ADDR_W-1:0]                     wdata_i,
    output logic [2*NUM_RANGES-1:0][ADDR_W-1:0]   pt_o,
    output logic                                  en_o,
    output logic                                  opmode_o,
    output perm_t [NUM_RANGES-1:0]                perm_o,
    output logic                                  clr_o
);

    localparam int unsigned NUM_PTS = 2 * NUM_RANGES;
    localparam int unsigned PT_W    = $clog2(NUM_PTS);
    localparam logic [IDX_W-1:0] CTRL_IDX = IDX_W'(NUM_PTS);
    localparam logic [IDX_W-1:0] CLR_IDX  = IDX_W'(NUM_PTS + 1);

    typedef struct packed {
        logic [NUM_PTS-1:0][ADDR_W-1:0] pt;
        logic                           en;
        logic                           opm;
        perm_t [NUM_RANGES-1:0]         perm;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (rst) begin
            cfg_d = '0;
        end else if (we_i) begin
            if (idx_i < CTRL_IDX) begin
                cfg_d.pt[idx_i[PT_W-1:0]] = wdata_i;
            end else if (idx_i == CTRL_IDX) begin
                cfg_d.en  = wdata_i[CTRL_EN_BIT];
                cfg_d.opm = wdata_i[CTRL_TYPE_BIT];
                for (int r = 0; r < int'(NUM_RANGES); r++) begin
                    cfg_d.perm[r].exec = wdata_i[CTRL_PERM_LSB + PERM_BITS*r];
                    cfg_d.perm[r].rd   = wdata_i[CTRL_PERM_LSB + PERM_BITS*r + 1];
                    cfg_d.perm[r].wr   = wdata_i[CTRL_PERM_LSB + PERM_BITS*r + 2];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        cfg_q <= cfg_d;
    end

    assign pt_o     = cfg_q.pt;
    assign en_o     = cfg_q.en;
    assign opmode_o = cfg_q.opm;
    assign perm_o   = cfg_q.perm;
    assign clr_o    = we_i && (idx_i == CLR_IDX) && wdata_i[0];

endmodule

// File: rtl/mpu_window_cmp.sv
module mpu_window_cmp #(
    parameter int unsigned ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] lo_i,
    input  logic [ADDR_W-1:0] hi_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o
);

    logic above_lo;
    logic below_hi;

    always_comb begin
        above_lo = (addr_i >= lo_i);
        below_hi = (addr_i <= hi_i);
        hit_o    = above_lo && below_hi;
    end

endmodule

// File: rtl/mpu_viol_capture.sv
module mpu_viol_capture #(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              viol_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              clr_i,
    output logic              flag_o,
    output logic [ADDR_W-1:0] addr_o
);

    typedef struct packed {
        logic              flag;
        logic [ADDR_W-1:0] addr;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (rst) begin
            cap_d = '0;
        end else if (viol_i && (!cap_q.flag || clr_i)) begin
            cap_d.flag = 1'b1;
            cap_d.addr = addr_i;
        end else if (clr_i) begin
            cap_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        cap_q <= cap_d;
    end

    assign flag_o = cap_q.flag;
    assign addr_o = cap_q.addr;

endmodule

// File: rtl/mpu_range_guard.sv
module mpu_range_guard
    import mpu_grp_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned NUM_RANGES = 2,
    parameter int unsigned IDX_W      = $clog2(2 * NUM_RANGES + 2)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_addr,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_kind,
    output logic              viol_flag,
    output logic [ADDR_W-1:0] viol_addr
);

    localparam int unsigned NUM_PTS = 2 * NUM_RANGES;

    logic [NUM_PTS-1:0][ADDR_W-1:0] pts;
    logic                           cfg_en;
    logic                           cfg_opm;
    perm_t [NUM_RANGES-1:0]         perms;
    logic                           clr_pulse;
    logic [NUM_RANGES-1:0]          hit;
    logic [NUM_RANGES-1:0]          grant;
    logic                           kind_ok;
    logic                           viol_now;

    mpu_cfg_regs #(
        .ADDR_W    (ADDR_W),
        .NUM_RANGES(NUM_RANGES),
        .IDX_W     (IDX_W)
    ) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .we_i    (cfg_we),
        .idx_i   (cfg_addr),
        .wdata_i (cfg_wdata),
        .pt_o    (pts),
        .en_o    (cfg_en),
        .opmode_o(cfg_opm),
        .perm_o  (perms),
        .clr_o   (clr_pulse)
    );

    for (genvar g = 0; g < NUM_RANGES; g++) begin : g_win
        mpu_window_cmp #(.ADDR_W(ADDR_W)) u_win (
            .lo_i  (pts[2*g]),
            .hi_i  (pts[2*g+1]),
            .addr_i(acc_addr),
            .hit_o (hit[g])
        );
    end

    always_comb begin
        if (cfg_opm) begin
            kind_ok = (acc_kind == ACC_READ) || (acc_kind == ACC_WRITE);
        end else begin
            kind_ok = (acc_kind == ACC_FETCH);
        end
        for (int r = 0; r < int'(NUM_RANGES); r++) begin
            if (!cfg_opm) begin
                grant[r] = hit[r] && perms[r].exec;
            end else if (acc_kind == ACC_WRITE) begin
                grant[r] = hit[r] && perms[r].wr;
            end else begin
                grant[r] = hit[r] && perms[r].rd;
            end
        end
        viol_now = acc_valid && cfg_en && kind_ok && (|hit) && !(|grant);
    end

    mpu_viol_capture #(.ADDR_W(ADDR_W)) u_cap (
        .clk   (clk),
        .rst   (rst),
        .viol_i(viol_now),
        .addr_i(acc_addr),
        .clr_i (clr_pulse),
        .flag_o(viol_flag),
        .addr_o(viol_addr)
    );

endmodule

// File: rtl/mpu_range_guard_chk.sv
module mpu_range_guard_chk #(
    parameter int unsigned ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              acc_valid,
    input logic              viol_flag,
    input logic [ADDR_W-1:0] viol_addr,
    input logic              en,
    input logic              clr,
    input logic              viol_now
);

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (!viol_flag && viol_addr == '0));

    assert_off_never_sets_R2: assert property (@(posedge clk) disable iff (rst)
        (!viol_flag && !en) |=> !viol_flag);

    assert_rise_after_valid_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(viol_flag) |-> $past(acc_valid));

    assert_sticky_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (viol_flag && !clr) |=> (viol_flag && $stable(viol_addr)));

    assert_clear_drops_R10: assert property (@(posedge clk) disable iff (rst)
        (clr && !viol_now) |=> !viol_flag);

    assert_set_wins_R10: assert property (@(posedge clk) disable iff (rst)
        viol_now |=> viol_flag);

endmodule

bind mpu_range_guard mpu_range_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .acc_valid(acc_valid),
    .viol_flag(viol_flag),
    .viol_addr(viol_addr),
    .en       (cfg_en),
    .clr      (clr_pulse),
    .viol_now (viol_now)
);

// File: tb/test_mpu_range_guard.sv
module test_mpu_range_guard;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [1:0]  acc_kind = '0;
    logic        viol_flag;
    logic [31:0] viol_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench model of programmed state
    logic [31:0] m_pt [4];
    logic        m_en, m_opm;
    logic [2:0]  m_perm [2];   // {exec, read, write}
    logic        e_flag;
    logic [31:0] e_addr;

    always #2 clk = ~clk;

    mpu_range_guard i_mpu_range_guard (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_kind(acc_kind), .viol_flag(viol_flag), .viol_addr(viol_addr)
    );

    function automatic logic [31:0] mk_ctrl(input bit en, input bit opm,
                                            input bit x0, input bit r0, input bit w0,
                                            input bit x1, input bit r1, input bit w1);
        return {24'd0, w1, r1, x1, w0, r0, x0, opm, en};
    endfunction

    function automatic logic model_viol(input logic [31:0] a, input logic [1:0] k);
        logic kind_ok, any_hit, any_grant, in_w, need;
        kind_ok = m_opm ? (k == 2'd1 || k == 2'd2) : (k == 2'd0);
        any_hit = 1'b0;
        any_grant = 1'b0;
        for (int w = 0; w < 2; w++) begin
            in_w = (a >= m_pt[2*w]) && (a <= m_pt[2*w+1]);
            need = !m_opm ? m_perm[w][2] : (k == 2'd2 ? m_perm[w][0] : m_perm[w][1]);
            any_hit   = any_hit | in_w;
            any_grant = any_grant | (in_w & need);
        end
        return m_en && kind_ok && any_hit && !any_grant;
    endfunction

    task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_write(input logic [2:0] idx, input logic [31:0] d);
        if (idx < 3'd4) m_pt[idx[1:0]] = d;
        else if (idx == 3'd4) begin
            m_en = d[0]; m_opm = d[1];
            m_perm[0] = {d[2], d[3], d[4]};
            m_perm[1] = {d[5], d[6], d[7]};
        end
    endtask

    task automatic cfg_write(input logic [2:0] idx, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = idx; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        model_write(idx, d);
        if (idx == 3'd5 && d[0]) e_flag = 1'b0;
    endtask

    task automatic check_state(input string req);
        check_eq({req, " flag"}, {31'd0, viol_flag}, {31'd0, e_flag});
        check_eq({req, " addr"}, viol_addr, e_addr);
    endtask

    // one access, optionally together with a clear command
    task automatic access(input string req, input logic [31:0] a, input logic [1:0] k,
                          input bit with_clr);
        logic v;
        @(negedge clk);
        v = model_viol(a, k);
        acc_valid = 1'b1; acc_addr = a; acc_kind = k;
        if (with_clr) begin cfg_we = 1'b1; cfg_addr = 3'd5; cfg_wdata = 32'd1; end
        @(negedge clk);
        acc_valid = 1'b0; cfg_we = 1'b0;
        if (v && (!e_flag || with_clr)) begin
            e_flag = 1'b1; e_addr = a;
        end else if (with_clr) begin
            e_flag = 1'b0;
        end
        check_state(req);
    endtask

    task automatic clear_and_check(input string req);
        cfg_write(3'd5, 32'd1);
        check_state(req);
    endtask

    task automatic report();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            report();
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) m_pt[i] = '0;
        m_en = 0; m_opm = 0; m_perm[0] = 0; m_perm[1] = 0;
        e_flag = 0; e_addr = 0;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_state("R1 reset");

        // R1: points at 0 and no permissions after reset -> address 0 violates
        cfg_write(3'd4, mk_ctrl(1,0, 0,0,0, 0,0,0));
        access("R1 cleared perms", 32'h0, 2'd0, 0);
        clear_and_check("R10 clear");

        // R2: disabled group never flags
        cfg_write(3'd0, 32'h1000); cfg_write(3'd1, 32'h1FFF);
        cfg_write(3'd2, 32'h3000); cfg_write(3'd3, 32'h3FFF);
        cfg_write(3'd4, mk_ctrl(0,0, 0,0,0, 0,0,0));
        access("R2 disabled fetch", 32'h1800, 2'd0, 0);
        cfg_write(3'd4, mk_ctrl(0,1, 0,0,0, 0,0,0));
        access("R2 disabled write", 32'h3800, 2'd2, 0);

        // R3/R4/R8: execute checking on fetches
        cfg_write(3'd4, mk_ctrl(1,0, 0,1,1, 1,0,0));
        access("R3 lower bound", 32'h1000, 2'd0, 0);
        clear_and_check("R10 clear");
        access("R3 upper bound", 32'h1FFF, 2'd0, 0);
        clear_and_check("R10 clear");
        access("R3 below lower", 32'h0FFF, 2'd0, 0);
        access("R3 above upper", 32'h2000, 2'd0, 0);
        access("R8 outside both", 32'h8000_0000, 2'd0, 0);
        access("R4 execute granted", 32'h3000, 2'd0, 0);
        access("R6 read under type0", 32'h1800, 2'd1, 0);
        access("R6 write under type0", 32'h1800, 2'd2, 0);

        // R5: read/write checking on operands
        cfg_write(3'd4, mk_ctrl(1,1, 1,1,0, 1,0,1));
        access("R5 read granted", 32'h1800, 2'd1, 0);
        access("R5 write denied", 32'h1800, 2'd2, 0);
        clear_and_check("R10 clear");
        access("R5 read denied", 32'h3800, 2'd1, 0);
        clear_and_check("R10 clear");
        access("R5 write granted", 32'h3800, 2'd2, 0);
        access("R6 fetch under type1", 32'h1800, 2'd0, 0);
        access("R6 kind none", 32'h1800, 2'd3, 0);

        // R7: overlap, either window grants
        cfg_write(3'd2, 32'h1800);
        access("R7 overlap read", 32'h1900, 2'd1, 0);
        access("R7 overlap write", 32'h1900, 2'd2, 0);

        // R11: inverted window matches nothing
        cfg_write(3'd0, 32'h5000); cfg_write(3'd1, 32'h4000);
        cfg_write(3'd4, mk_ctrl(1,1, 0,0,0, 0,0,0));
        access("R11 inverted inside", 32'h4800, 2'd1, 0);
        access("R11 inverted at lower", 32'h5000, 2'd1, 0);

        // R9: capture timing and first address held
        access("R9 first capture", 32'h2000, 2'd1, 0);
        access("R9 sticky holds first", 32'h2004, 2'd2, 0);
        access("R9 allowed access keeps", 32'h9000, 2'd1, 0);

        // R10: violation together with clear wins
        access("R10 set wins", 32'h2008, 2'd1, 1);
        access("R10 clear no new", 32'h9000, 2'd1, 1);

        // random mix
        for (int it = 0; it < 400; it++) begin
            logic [31:0] base;
            base = $urandom & 32'hFFFF_FF00;
            if (it % 8 == 0) begin
                for (int p = 0; p < 4; p++) cfg_write(3'(p), base + ($urandom % 64));
                cfg_write(3'd4, {24'd0, 8'($urandom) | 8'h01});
            end
            access("R4 R5 R7 R8 random", base + ($urandom % 80) - 8, 2'($urandom), 0);
            if (e_flag) clear_and_check("R10 random clear");
        end

        done = 1'b1;
        report();
    end

endmodule